// File: doc/BRIEF.md
# Error Flag Qualifier and Summary

This block takes a set of raw fault lines from analog monitors and turns each into a clean status bit. It then folds those bits into one active-high summary flag. The raw lines and a buffer-busy line arrive with no timing relation to the system clock, so they first pass through a synchronizer. After that, each source is qualified by its own counter, which advances only on a slow tick enable (nominally 1 MHz). A fault must be seen on a programmable number of consecutive ticks before it counts. The 4-bit delay code maps onto a nonlinear set of tick counts.

While the buffer-busy input is active, faults can be held off, and the tick count for them begins only once the buffer goes idle. The busy line's active level is selectable, and a control bit lets faults through even while the buffer is busy. Each status bit is either sticky, in which case software clears it with a write-one pulse, or it follows the qualified fault in real time; the qualification delay applies in both modes. Five of the sources can be dropped from the summary by a mask bit. The checksum source always reaches the summary.

The configuration inputs are plain levels taken from a register file elsewhere. The clear input is a per-bit pulse one system clock wide.

Top module: `err_flag_qual`

## Requirements
- R1: Bit order of `err_raw_i`, `clr_i` and `status_o`: 0 input overvoltage, 1 gain, 2 output, 3 input clamp, 4 input amplifier, 5 checksum. `mask_i[i]` = 1 removes status bit i (i = 0..4) from the summary flag. The checksum bit (5) has no mask. `flag_o` is the OR of the status bits that are not removed.
- R2: While `rst` is high, and on the first cycle after it, `status_o` is all zero and `flag_o` is 0.
- R3: A source's status sets on the tick at which its synchronized fault has been seen, unblocked, for N+1 consecutive ticks. N depends on `supp_code_i`: codes 0 to 8 give N equal to the code, then 9 gives 12, 10 gives 16, 11 gives 24, 12 gives 32, 13 gives 48, 14 gives 64 and 15 gives 127. Code 0 qualifies on the first tick.
- R4: If a fault is absent, or is blocked, on any tick, that source's count restarts from zero.
- R5: The buffer is active when `buf_raw_i` is 1 with `buf_pol_i` = 0, and when `buf_raw_i` is 0 with `buf_pol_i` = 1.
- R6: With `det_in_buf_i` = 0, faults are blocked while the buffer is active, and counting starts on the first tick after the buffer goes idle. With `det_in_buf_i` = 1, the buffer state has no effect.
- R7: With `latch_dis_i` = 0, a set status bit holds until a `clr_i` pulse on that bit. If a clear and a qualifying tick fall in the same cycle, the bit stays set. A fault that is still qualified sets the bit again on the next tick.
- R8: With `latch_dis_i` = 1, each status bit takes its qualified value on every tick and holds between ticks. The R3 delay still applies, and `clr_i` has no effect.
- R9: `err_raw_i` and `buf_raw_i` pass through a 2-stage synchronizer. A level present at a clock edge is first used by qualification at the second edge after it.
- R10: Counters and status bits change only on cycles with `tick_i` high; a `clr_i` pulse is the only other event that can change a status bit.
- R11: `flag_o` is registered and changes on the same edge as `status_o`, using the mask value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow tick enable, one clock wide |
| err_raw_i | input | 6 | Raw fault lines, asynchronous |
| buf_raw_i | input | 1 | Raw buffer-busy line, asynchronous |
| buf_pol_i | input | 1 | Buffer-busy polarity, 1 = low is active |
| det_in_buf_i | input | 1 | 1 = detect faults while the buffer is active |
| latch_dis_i | input | 1 | 1 = status follows qualified fault, no latching |
| supp_code_i | input | 4 | Qualification delay code |
| mask_i | input | 5 | Per-source removal from the summary flag |
| clr_i | input | 6 | Write-one-to-clear pulses for status bits |
| status_o | output | 6 | Per-source status bits |
| flag_o | output | 1 | Summary fault flag, active high |

## Verification
A wrong count or a bad delay-code decode shows at the ports as a status bit rising one or more ticks early or late. A counter that fails to restart shows as a bit that sets after a broken run of faults. The reference model runs alongside the design and is compared on every clock, so any such error is caught on the first cycle at which `status_o` or `flag_o` disagrees. That is never later than the tick at which the bit should have changed. Blocking, polarity and clear priority errors show the same way, within one tick period of the stimulus that exposes them.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int CNT_W   = 7;
  localparam int CODE_W  = 4;

  // Nonlinear delay code to tick count
  function automatic logic [CNT_W-1:0] supp_ticks(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      4'd9:    n = 7'd12;
      4'd10:   n = 7'd16;
      4'd11:   n = 7'd24;
      4'd12:   n = 7'd32;
      4'd13:   n = 7'd48;
      4'd14:   n = 7'd64;
      4'd15:   n = 7'd127;
      default: n = {{(CNT_W-CODE_W){1'b0}}, code};
    endcase
    return n;
  endfunction
endpackage

// File: rtl/errq_sync.sv
module errq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/errq_chan.sv
module errq_chan #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          err_s,
  input  logic          blocked,
  input  logic [CW-1:0] limit,
  input  logic          latch_dis,
  input  logic          clr,
  output logic          st_next,
  output logic          status
);
  logic [CW-1:0] cnt;
  logic          seen;
  logic          hit;

  assign seen = err_s & ~blocked;
  assign hit  = seen & (cnt >= limit);

  always_comb begin
    st_next = status;
    if (!latch_dis && clr) st_next = 1'b0;
    if (tick) begin
      if (latch_dis)  st_next = hit;
      else if (hit)   st_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      status <= 1'b0;
    end else begin
      if (tick) begin
        if (!seen)            cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
      end
      status <= st_next;
    end
  end
endmodule

// File: rtl/err_flag_qual.sv
module err_flag_qual
  import errq_pkg::*;
#(
  parameter int N_MASK      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [N_MASK:0]   err_raw_i,
  input  logic              buf_raw_i,
  input  logic              buf_pol_i,
  input  logic              det_in_buf_i,
  input  logic              latch_dis_i,
  input  logic [CODE_W-1:0] supp_code_i,
  input  logic [N_MASK-1:0] mask_i,
  input  logic [N_MASK:0]   clr_i,
  output logic [N_MASK:0]   status_o,
  output logic              flag_o
);
  localparam int N_SRC = N_MASK + 1;

  logic [N_SRC:0]   sync_q;
  logic [N_SRC-1:0] err_s;
  logic             buf_s;
  logic             blocked;
  logic [CNT_W-1:0] limit;
  logic [N_SRC-1:0] st_next;
  logic [N_SRC-1:0] enable;

  errq_sync #(.W(N_SRC + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({buf_raw_i, err_raw_i}),
    .q   (sync_q)
  );

  assign err_s   = sync_q[N_SRC-1:0];
  assign buf_s   = sync_q[N_SRC];
  assign blocked = (buf_s ^ buf_pol_i) & ~det_in_buf_i;
  assign limit   = supp_ticks(supp_code_i);
  assign enable  = {1'b1, ~mask_i};

  for (genvar i = 0; i < N_SRC; i++) begin : g_chan
    errq_chan #(.CW(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick_i),
      .err_s     (err_s[i]),
      .blocked   (blocked),
      .limit     (limit),
      .latch_dis (latch_dis_i),
      .clr       (clr_i[i]),
      .st_next   (st_next[i]),
      .status    (status_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= |(st_next & enable);
  end
endmodule

// File: rtl/err_flag_qual_chk.sv
module err_flag_qual_chk #(
  parameter int N_SRC = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             latch_dis_i,
  input logic [N_SRC-1:0] clr_i,
  input logic [N_SRC-1:0] status_o,
  input logic             flag_o
);
  // R2: reset clears everything
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !flag_o));

  // R1: checksum source can never be masked
  assert_cksum_unmasked_R1: assert property (@(posedge clk) disable iff (rst)
    status_o[N_SRC-1] |-> flag_o);

  // R1: flag needs at least one status bit
  assert_flag_needs_status_R1: assert property (@(posedge clk) disable iff (rst)
    (status_o == '0) |-> !flag_o);

  // R10: a status bit rises only after a tick
  assert_rise_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (|(status_o & ~$past(status_o))) |-> $past(tick_i));

  // R7 / R8: a bit falls without clear only in follow mode on a tick
  assert_hold_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_o) & ~status_o & ~$past(clr_i))) |-> ($past(latch_dis_i) && $past(tick_i)));
endmodule

bind err_flag_qual err_flag_qual_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .latch_dis_i (latch_dis_i),
  .clr_i       (clr_i),
  .status_o    (status_o),
  .flag_o      (flag_o)
);

// File: tb/err_flag_qual_tb.sv
module err_flag_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM         = 5;
  localparam int NS         = NM + 1;
  localparam int MAX_CYC    = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick_i;
  logic [NS-1:0] err_raw_i;
  logic          buf_raw_i, buf_pol_i, det_in_buf_i, latch_dis_i;
  logic [3:0]    supp_code_i;
  logic [NM-1:0] mask_i;
  logic [NS-1:0] clr_i;
  logic [NS-1:0] status_o;
  logic          flag_o;

  err_flag_qual u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .err_raw_i(err_raw_i),
    .buf_raw_i(buf_raw_i), .buf_pol_i(buf_pol_i), .det_in_buf_i(det_in_buf_i),
    .latch_dis_i(latch_dis_i), .supp_code_i(supp_code_i), .mask_i(mask_i),
    .clr_i(clr_i), .status_o(status_o), .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  int    tick_period = 4;
  int    tcount = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R2";

  // reference model state
  bit [NS-1:0] m_e1, m_e2, m_st;
  bit          m_b1, m_b2, m_flag;
  int          m_cnt [NS];

  function automatic int lim_of(input int c);
    case (c)
      9: return 12;   10: return 16;  11: return 24;  12: return 32;
      13: return 48;  14: return 64;  15: return 127;
      default: return c;
    endcase
  endfunction

  always @(posedge clk) begin
    bit act, blk, ok, hit, ns;
    int lim;
    started <= 1;
    if (rst) begin
      m_e1 = '0; m_e2 = '0; m_b1 = 0; m_b2 = 0; m_st = '0; m_flag = 0;
      for (int i = 0; i < NS; i++) m_cnt[i] = 0;
    end else begin
      act = m_b2 ^ buf_pol_i;
      blk = act && !det_in_buf_i;
      lim = lim_of(int'(supp_code_i));
      for (int i = 0; i < NS; i++) begin
        ns = m_st[i];
        if (!latch_dis_i && clr_i[i]) ns = 0;
        if (tick_i) begin
          ok  = m_e2[i] && !blk;
          hit = ok && (m_cnt[i] >= lim);
          if (!ok) m_cnt[i] = 0;
          else if (m_cnt[i] < lim) m_cnt[i] = m_cnt[i] + 1;
          if (latch_dis_i) ns = hit;
          else if (hit)    ns = 1;
        end
        m_st[i] = ns;
      end
      m_flag = |(m_st & {1'b1, ~mask_i});
      m_e2 = m_e1; m_e1 = err_raw_i;
      m_b2 = m_b1; m_b1 = buf_raw_i;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (status_o !== m_st || flag_o !== m_flag) begin
        fails++;
        $display("FAIL %s t=%0t status=%b expected=%b flag=%b expected=%b",
                 tag, $time, status_o, m_st, flag_o, m_flag);
      end
    end
    tcount++;
    tick_i <= (tcount % tick_period) == 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYC && !done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog cycles=%0d expected<%0d", cycles, MAX_CYC);
      report();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_i = '1;
    @(negedge clk); clr_i = '0;
  endtask

  initial begin
    rst = 1; tick_i = 0; err_raw_i = '0; buf_raw_i = 0; buf_pol_i = 0;
    det_in_buf_i = 0; latch_dis_i = 0; supp_code_i = 4'd1; mask_i = '0; clr_i = '0;
    idle(5);
    // R2: explicit reset state check
    vectors++;
    if (status_o !== '0 || flag_o !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset status=%b expected=0 flag=%b expected=0", status_o, flag_o);
    end
    rst = 0;
    idle(3);

    // R3 / R9: every delay code, one source at a time
    tag = "R3";
    for (int c = 0; c < 16; c++) begin
      supp_code_i = 4'(c);
      err_raw_i = '0; err_raw_i[c % NS] = 1'b1;
      idle((lim_of(c) + 4) * tick_period + 8);
      err_raw_i = '0;
      idle(10);
      clear_all();
      idle(3);
    end

    // R10: slower tick
    tag = "R10"; tick_period = 7; supp_code_i = 4'd5;
    err_raw_i = 6'b000100; idle(60); clr_i = 6'b000100; idle(1); clr_i = '0; idle(30);
    err_raw_i = '0; clear_all(); tick_period = 4;

    // R4: broken runs restart the count
    tag = "R4"; supp_code_i = 4'd8;
    for (int k = 0; k < 4; k++) begin
      err_raw_i = 6'b000011; idle(5 * 4);
      err_raw_i = '0;        idle(4);
    end
    err_raw_i = 6'b000011; idle(12 * 4);
    err_raw_i = '0; clear_all(); idle(8);

    // R5 / R6: buffer blocking with both polarities
    tag = "R5"; supp_code_i = 4'd3;
    for (int p = 0; p < 2; p++) begin
      buf_pol_i = p[0];
      buf_raw_i = ~p[0]; idle(8);
      err_raw_i = 6'b001000; idle(40);
      buf_raw_i = p[0];      idle(30);
      err_raw_i = '0; clear_all(); idle(8);
    end
    tag = "R6"; buf_pol_i = 0; det_in_buf_i = 1; buf_raw_i = 1;
    err_raw_i = 6'b010000; idle(30);
    det_in_buf_i = 0; idle(20); buf_raw_i = 0; idle(30);
    err_raw_i = '0; clear_all(); idle(8);

    // R7: sticky bits, clear while fault persists
    tag = "R7"; supp_code_i = 4'd2;
    err_raw_i = 6'b100001; idle(30);
    clr_i = 6'b100001; idle(1); clr_i = '0; idle(12);
    err_raw_i = '0; idle(20);
    clr_i = 6'b000001; idle(1); clr_i = '0; idle(8);
    clear_all(); idle(8);

    // R8: follow mode, clear ignored
    tag = "R8"; latch_dis_i = 1; supp_code_i = 4'd4;
    for (int k = 0; k < 3; k++) begin
      err_raw_i = 6'b010101; idle(40);
      clr_i = '1; idle(1); clr_i = '0;
      err_raw_i = 6'b101010; idle(40);
    end
    err_raw_i = '0; idle(40); latch_dis_i = 0; clear_all();

    // R1 / R11: walk all masks with maskable faults set
    tag = "R1"; supp_code_i = 4'd0;
    err_raw_i = 6'b011111; idle(20);
    for (int m = 0; m < 32; m++) begin
      mask_i = 5'(m); idle(3);
    end
    tag = "R11";
    err_raw_i = 6'b100000; idle(12);
    for (int m = 31; m >= 0; m--) begin
      mask_i = 5'(m); idle(2);
    end
    err_raw_i = '0; mask_i = '0; clear_all(); idle(8);

    // R9: random traffic including sync edges and clear/tick collisions
    tag = "R9";
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      err_raw_i = 6'($urandom);
      if (($urandom % 8) == 0)  buf_raw_i = ~buf_raw_i;
      if (($urandom % 200) == 0) buf_pol_i = ~buf_pol_i;
      if (($urandom % 150) == 0) det_in_buf_i = ~det_in_buf_i;
      if (($urandom % 300) == 0) latch_dis_i = ~latch_dis_i;
      if (($urandom % 100) == 0) supp_code_i = 4'($urandom % 5);
      if (($urandom % 50) == 0)  mask_i = 5'($urandom);
      if (($urandom % 400) == 0) tick_period = 1 + int'($urandom % 3);
      clr_i = (($urandom % 6) == 0) ? 6'($urandom) : '0;
      if (($urandom % 3) != 0) err_raw_i = err_raw_i | 6'b000110;
    end
    clr_i = '0;
    idle(4);
    done = 1;
    report();
  end
endmodule